// File: doc/BRIEF.md
# Micro-Operation Sequencing Control Unit

This block is a hardwired control unit for a small accumulator machine. It comes with the datapath registers it steers and a behavioural word memory. A 2-bit cycle code and a timing-step counter walk the machine through four phases: instruction fetch, indirect address resolution, execute and interrupt entry. Each phase is a fixed, grouped schedule of register transfers. In every step the control unit decodes the cycle code, the step, the opcode and one datapath flag into load enables for the program counter, the address register (MAR), the buffer register (MBR), the instruction register, the accumulator and the interrupt-enable flag. It also drives the memory read and write strobes.

Any step that touches memory waits for the memory-ready input. While that input is low, every register and the step counter hold their values. An instruction word carries an indirect flag in bit DW-1, a 3-bit opcode in bits DW-2 down to DW-4, and an operand address in the low AW bits. A load port writes words into the memory so that programs can be placed before or during a run. The bus outputs show the memory transaction that the current step presents.

Top module: `mcu_core`

## Requirements
- R1: While `rst` is high and just after it falls, the cycle code is 00, the step is 0, and PC, AC and the interrupt-enable flag are all zero.
- R2: Fetch takes three steps. Step 0 copies PC into MAR. Step 1 reads memory at MAR into MBR and adds one to PC in the same step. Step 2 copies MBR into the instruction register.
- R3: When a step that reads or writes memory sees `mem_ready` low, the step counter, the cycle code, PC, MAR, MBR, IR and AC all keep their values until `mem_ready` is high at a clock edge.
- R4: Cycle codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt. After fetch the code becomes 01 if bit DW-1 of the fetched word is 1, and 10 otherwise.
- R5: The indirect cycle reads the word addressed by the IR address field. It then replaces only that field with the low AW bits of the word read and continues to execute with the opcode bits unchanged.
- R6: Opcode 000 (ADD) reads the operand word and leaves AC = (AC + operand) mod 2^DW.
- R7: Opcode 001 (ISZ) reads the operand, increments it mod 2^DW and writes it back to the same address. If the written value is zero, PC is incremented once more, which skips the next instruction.
- R8: Opcode 010 sets the interrupt-enable flag. Any other opcode beyond 001 does nothing. At the end of execute the next cycle is interrupt only if `irq` is high and the flag was already set; otherwise it is fetch.
- R9: The interrupt cycle writes the current PC to memory address SAVE_ADDR, loads PC with HANDLER_ADDR, clears the interrupt-enable flag and returns to fetch.
- R10: A memory read never happens in the same step that loads MAR, and MBR and IR are never loaded in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request level |
| mem_ready | input | 1 | Memory ready; low stalls memory steps |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | AW | Load-port word address |
| ld_data | input | DW | Load-port write data |
| cyc_code | output | 2 | Current cycle code |
| step | output | 2 | Current timing step |
| pc | output | AW | Program counter |
| ac | output | DW | Accumulator |
| ir | output | DW | Instruction register |
| ie | output | 1 | Interrupt-enable flag |
| bus_addr | output | AW | Memory address (MAR) |
| bus_wdata | output | DW | Memory write data (MBR) |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |

## Verification
Some properties are checked by assertions on every cycle. These are the step ordering rules, the freeze of all state during a memory stall, the one-step PC advance in fetch, the restricted exits from fetch, the ISZ skip, and the state found on return from an interrupt. Arithmetic results can only be shown by the bench's programs. These include the ADD sums across carry and wrap boundaries, the ISZ write-back values, the rewrite of the address field by an indirect pointer whose upper bits are set, and the difference between a request that arrives with the enable flag clear and one that arrives with it set. The bench also reruns the ADD and ISZ sweeps with a periodic ready pattern, to show that stalls leave results unchanged.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

   typedef enum logic [1:0] {
      CYC_FETCH = 2'b00,
      CYC_INDIR = 2'b01,
      CYC_EXEC  = 2'b10,
      CYC_INTR  = 2'b11
   } cyc_e;

   localparam int STEP_W = 2;
   localparam int OPW    = 3;

   localparam logic [OPW-1:0] OP_ADD = 3'd0;
   localparam logic [OPW-1:0] OP_ISZ = 3'd1;
   localparam logic [OPW-1:0] OP_ION = 3'd2;

   typedef struct packed {
      logic mar_pc;
      logic mar_ir;
      logic mar_save;
      logic mem_rd;
      logic mem_wr;
      logic mbr_mem;
      logic mbr_pc;
      logic mbr_inc;
      logic ir_mbr;
      logic ir_addr_mbr;
      logic pc_inc;
      logic pc_vec;
      logic ac_add;
      logic ie_set;
      logic ie_clr;
      logic last;
   } ctl_t;

endpackage

// File: rtl/mcu_decoder.sv
module mcu_decoder
   import mcu_pkg::*;
(
   input  cyc_e                  cyc,
   input  logic [STEP_W-1:0]     step,
   input  logic [OPW-1:0]        opcode,
   input  logic                  mbr_zero,
   output ctl_t                  ctl
);

   always_comb begin
      ctl = '0;
      unique case (cyc)
         CYC_FETCH: begin
            case (step)
               2'd0:    ctl.mar_pc = 1'b1;
               2'd1:    begin ctl.mem_rd = 1'b1; ctl.mbr_mem = 1'b1; ctl.pc_inc = 1'b1; end
               default: begin ctl.ir_mbr = 1'b1; ctl.last = 1'b1; end
            endcase
         end
         CYC_INDIR: begin
            case (step)
               2'd0:    ctl.mar_ir = 1'b1;
               2'd1:    begin ctl.mem_rd = 1'b1; ctl.mbr_mem = 1'b1; end
               default: begin ctl.ir_addr_mbr = 1'b1; ctl.last = 1'b1; end
            endcase
         end
         CYC_EXEC: begin
            if (opcode == OP_ADD) begin
               case (step)
                  2'd0:    ctl.mar_ir = 1'b1;
                  2'd1:    begin ctl.mem_rd = 1'b1; ctl.mbr_mem = 1'b1; end
                  default: begin ctl.ac_add = 1'b1; ctl.last = 1'b1; end
               endcase
            end else if (opcode == OP_ISZ) begin
               case (step)
                  2'd0:    ctl.mar_ir = 1'b1;
                  2'd1:    begin ctl.mem_rd = 1'b1; ctl.mbr_mem = 1'b1; end
                  2'd2:    ctl.mbr_inc = 1'b1;
                  default: begin ctl.mem_wr = 1'b1; ctl.pc_inc = mbr_zero; ctl.last = 1'b1; end
               endcase
            end else if (opcode == OP_ION) begin
               ctl.ie_set = 1'b1;
               ctl.last   = 1'b1;
            end else begin
               ctl.last = 1'b1;
            end
         end
         default: begin
            if (step == 2'd0) begin
               ctl.mbr_pc   = 1'b1;
               ctl.mar_save = 1'b1;
            end else begin
               ctl.mem_wr = 1'b1;
               ctl.pc_vec = 1'b1;
               ctl.ie_clr = 1'b1;
               ctl.last   = 1'b1;
            end
         end
      endcase
   end

endmodule

// File: rtl/mcu_sequencer.sv
module mcu_sequencer
   import mcu_pkg::*;
#(
   parameter bit IRQ_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              last,
   input  logic              ind_bit,
   input  logic              irq,
   input  logic              ie,
   output cyc_e              cyc,
   output logic [STEP_W-1:0] step
);

   logic take_int;
   cyc_e cyc_nxt;

   generate
      if (IRQ_EN) begin : g_irq
         assign take_int = irq & ie;
      end else begin : g_no_irq
         logic unused_irq;
         assign unused_irq = irq & ie;
         assign take_int   = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (cyc)
         CYC_FETCH: cyc_nxt = ind_bit ? CYC_INDIR : CYC_EXEC;
         CYC_INDIR: cyc_nxt = CYC_EXEC;
         CYC_EXEC:  cyc_nxt = take_int ? CYC_INTR : CYC_FETCH;
         default:   cyc_nxt = CYC_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc  <= CYC_FETCH;
         step <= '0;
      end else if (adv) begin
         if (last) begin
            cyc  <= cyc_nxt;
            step <= '0;
         end else begin
            step <= step + 2'd1;
         end
      end
   end

   assert_seq_frozen_R3: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(step) && $stable(cyc)));

   assert_fetch_exit_R4: assert property (@(posedge clk) disable iff (rst)
      (cyc == CYC_FETCH && last && adv) |=> (cyc == CYC_INDIR || cyc == CYC_EXEC));

endmodule

// File: rtl/mcu_datapath.sv
module mcu_datapath
   import mcu_pkg::*;
#(
   parameter int DW           = 12,
   parameter int AW           = 6,
   parameter int SAVE_ADDR    = 62,
   parameter int HANDLER_ADDR = 48
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  ctl_t          ctl,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   output logic [AW-1:0] pc,
   output logic [AW-1:0] mar,
   output logic [DW-1:0] mbr,
   output logic [DW-1:0] ir,
   output logic [DW-1:0] ac,
   output logic          ie
);

   localparam int            DEPTH  = 1 << AW;
   localparam logic [AW-1:0] SAVE_A = AW'(SAVE_ADDR);
   localparam logic [AW-1:0] VEC_A  = AW'(HANDLER_ADDR);

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rdata;

   assign rdata = mem[mar];

   always_ff @(posedge clk) begin
      if (ld_we)
         mem[ld_addr] <= ld_data;
      else if (!rst && adv && ctl.mem_wr)
         mem[mar] <= mbr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         ac  <= '0;
         ie  <= 1'b0;
      end else if (adv) begin
         if (ctl.mar_pc)        mar <= pc;
         else if (ctl.mar_ir)   mar <= ir[AW-1:0];
         else if (ctl.mar_save) mar <= SAVE_A;

         if (ctl.mbr_mem)       mbr <= rdata;
         else if (ctl.mbr_pc)   mbr <= DW'(pc);
         else if (ctl.mbr_inc)  mbr <= mbr + DW'(1);

         if (ctl.ir_mbr)           ir <= mbr;
         else if (ctl.ir_addr_mbr) ir[AW-1:0] <= mbr[AW-1:0];

         if (ctl.pc_vec)        pc <= VEC_A;
         else if (ctl.pc_inc)   pc <= pc + AW'(1);

         if (ctl.ac_add)        ac <= ac + mbr;

         if (ctl.ie_clr)        ie <= 1'b0;
         else if (ctl.ie_set)   ie <= 1'b1;
      end
   end

   assert_regs_frozen_R3: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(pc) && $stable(mar) && $stable(mbr) && $stable(ir) && $stable(ac)));

   assert_indirect_keeps_op_R5: assert property (@(posedge clk) disable iff (rst)
      (adv && ctl.ir_addr_mbr) |=> ir[DW-1:AW] == $past(ir[DW-1:AW]));

endmodule

// File: rtl/mcu_core.sv
module mcu_core
   import mcu_pkg::*;
#(
   parameter int DW           = 12,
   parameter int AW           = 6,
   parameter int SAVE_ADDR    = 62,
   parameter int HANDLER_ADDR = 48,
   parameter bit IRQ_EN       = 1'b1
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          irq,
   input  logic          mem_ready,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   output logic [1:0]    cyc_code,
   output logic [1:0]    step,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] ac,
   output logic [DW-1:0] ir,
   output logic          ie,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_rd,
   output logic          bus_wr
);

   initial begin
      assert (DW >= 1 + OPW + AW) else $error("mcu_core: DW too small for flag, opcode and address");
      assert (AW >= 2 && AW <= 12) else $error("mcu_core: AW out of range");
      assert (SAVE_ADDR >= 0 && SAVE_ADDR < (1 << AW)) else $error("mcu_core: SAVE_ADDR out of range");
      assert (HANDLER_ADDR >= 0 && HANDLER_ADDR < (1 << AW)) else $error("mcu_core: HANDLER_ADDR out of range");
   end

   ctl_t              ctl;
   cyc_e              cyc;
   logic [STEP_W-1:0] stp;
   logic              adv;
   logic [AW-1:0]     mar;
   logic [DW-1:0]     mbr;

   assign adv = !((ctl.mem_rd || ctl.mem_wr) && !mem_ready);

   mcu_decoder i_dec (
      .cyc      (cyc),
      .step     (stp),
      .opcode   (ir[DW-2 -: OPW]),
      .mbr_zero (mbr == '0),
      .ctl      (ctl)
   );

   mcu_sequencer #(.IRQ_EN(IRQ_EN)) i_seq (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .last    (ctl.last),
      .ind_bit (mbr[DW-1]),
      .irq     (irq),
      .ie      (ie),
      .cyc     (cyc),
      .step    (stp)
   );

   mcu_datapath #(
      .DW(DW), .AW(AW), .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
   ) i_dp (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .ctl     (ctl),
      .ld_we   (ld_we),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .pc      (pc),
      .mar     (mar),
      .mbr     (mbr),
      .ir      (ir),
      .ac      (ac),
      .ie      (ie)
   );

   assign cyc_code  = cyc;
   assign step      = stp;
   assign bus_addr  = mar;
   assign bus_wdata = mbr;
   assign bus_rd    = ctl.mem_rd;
   assign bus_wr    = ctl.mem_wr;

   assert_read_apart_from_mar_R10: assert property (@(posedge clk) disable iff (rst)
      !(ctl.mem_rd && (ctl.mar_pc || ctl.mar_ir || ctl.mar_save)));

   assert_mbr_ir_apart_R10: assert property (@(posedge clk) disable iff (rst)
      !((ctl.mbr_mem || ctl.mbr_pc || ctl.mbr_inc) && (ctl.ir_mbr || ctl.ir_addr_mbr)));

   assert_fetch_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cyc == CYC_FETCH && stp == 2'd1 && adv) |=> pc == $past(pc) + AW'(1));

   assert_isz_skip_R7: assert property (@(posedge clk) disable iff (rst)
      (cyc == CYC_EXEC && stp == 2'd3 && adv && mbr == '0) |=> pc == $past(pc) + AW'(1));

   assert_intr_return_R9: assert property (@(posedge clk) disable iff (rst)
      (cyc == CYC_INTR && stp == 2'd1 && adv) |=>
         (pc == AW'(HANDLER_ADDR) && !ie && cyc == CYC_FETCH));

endmodule

// File: tb/test_mcu_core.sv
module test_mcu_core;

   localparam int DW   = 12;
   localparam int AW   = 6;
   localparam int SAVE = 62;
   localparam int HVEC = 48;
   localparam logic [DW-1:0] NOP = 12'h300;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          irq = 1'b0;
   logic          ready_force = 1'b1;
   logic          ready_mode  = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic [3:0]    rcnt = '0;
   logic          mem_ready;

   logic [1:0]    cyc_code, step;
   logic [AW-1:0] pc, bus_addr;
   logic [DW-1:0] ac, ir, bus_wdata;
   logic          ie, bus_rd, bus_wr;

   int checks = 0;
   int errors = 0;

   assign mem_ready = ready_mode ? (rcnt[1:0] != 2'd0) : ready_force;

   always #5 clk = ~clk;
   always @(negedge clk) rcnt <= rcnt + 4'd1;

   mcu_core #(.DW(DW), .AW(AW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HVEC)) i_mcu_core (
      .clk(clk), .rst(rst), .irq(irq), .mem_ready(mem_ready),
      .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .cyc_code(cyc_code), .step(step), .pc(pc), .ac(ac), .ir(ir), .ie(ie),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst = 1'b1;
   endtask

   task automatic run();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_for(input logic [1:0] c, input logic [1:0] s, input string req);
      int n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!(cyc_code == c && step == s) && n < 400);
      check(req, {cyc_code, step}, {c, s});
   endtask

   task automatic wait_pc(input int p, input string req);
      int n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!(cyc_code == 2'b00 && step == 2'd0 && pc == AW'(p)) && n < 400);
      check(req, 32'(pc), 32'(p));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual run >= 150000 cycles expected fewer");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] vals [6];
      logic [DW-1:0] ivals [7];
      vals  = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h5A5};
      ivals = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFE, 12'hFFF, 12'h0AB};

      // R1: reset state
      load(0, 12'h315);
      ready_force = 1'b0;
      run();
      #1;
      check("R1 cycle", 32'(cyc_code), 0);
      check("R1 step",  32'(step), 0);
      check("R1 pc",    32'(pc), 0);
      check("R1 ac",    32'(ac), 0);
      check("R1 ie",    32'(ie), 0);
      check("R10 no read in MAR step", 32'(bus_rd), 0);

      // R2 / R3 / R10: fetch schedule with a stall in the read step
      @(posedge clk); #1;
      check("R2 step1", 32'(step), 1);
      check("R2 read strobe", 32'(bus_rd), 1);
      check("R2 mar from pc", 32'(bus_addr), 0);
      repeat (3) @(posedge clk);
      #1;
      check("R3 step held", 32'(step), 1);
      check("R3 pc held", 32'(pc), 0);
      @(negedge clk);
      ready_force = 1'b1;
      @(posedge clk); #1;
      check("R2 step2", 32'(step), 2);
      check("R2 pc incremented", 32'(pc), 1);
      check("R10 ir not loaded with mbr", 32'(ir), 0);
      @(posedge clk); #1;
      check("R4 direct goes to execute", 32'(cyc_code), 2);
      check("R2 ir loaded", 32'(ir), 32'h315);

      // R6: ADD sweep, with and without stalls
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 6; b++) begin
            hold_reset();
            ready_mode = ((a + b) % 2) == 1;
            irq = 1'b0;
            load(0, 12'h028);
            load(1, 12'h029);
            load(2, NOP);
            load(40, vals[a]);
            load(41, vals[b]);
            run();
            wait_pc(2, "R6 reach");
            check("R6 sum", 32'(ac), 32'((vals[a] + vals[b]) & 12'hFFF));
         end
      end

      // R7: ISZ sweep
      for (int i = 0; i < 7; i++) begin
         logic [DW-1:0] nv;
         nv = ivals[i] + 12'd1;
         hold_reset();
         ready_mode = (i % 2) == 1;
         load(0, 12'h128);
         load(1, NOP);
         load(2, NOP);
         load(40, ivals[i]);
         run();
         wait_for(2'b10, 2'd3, "R7 reach write step");
         check("R7 write strobe", 32'(bus_wr), 1);
         check("R7 write addr", 32'(bus_addr), 40);
         check("R7 write data", 32'(bus_wdata), 32'(nv));
         wait_for(2'b00, 2'd0, "R7 back to fetch");
         check("R7 skip", 32'(pc), (nv == '0) ? 2 : 1);
      end

      // R4 / R5: indirect ADD through a pointer with set upper bits
      hold_reset();
      ready_mode = 1'b0;
      load(0, 12'h828);
      load(1, NOP);
      load(40, 12'hE29);
      load(41, 12'h123);
      run();
      wait_for(2'b01, 2'd0, "R4 indirect cycle entered");
      wait_for(2'b10, 2'd0, "R5 execute after indirect");
      check("R5 address field replaced", 32'(ir), 32'h829);
      wait_pc(1, "R5 reach");
      check("R5 operand via pointer", 32'(ac), 32'h123);

      // R8: request ignored while disabled
      hold_reset();
      irq = 1'b1;
      load(0, NOP);
      load(1, NOP);
      load(2, NOP);
      run();
      wait_pc(2, "R8 no interrupt when disabled");
      check("R8 ie stays clear", 32'(ie), 0);

      // R8 / R9: enable, then take the interrupt
      hold_reset();
      load(0, 12'h200);
      load(1, NOP);
      load(2, NOP);
      load(HVEC, NOP);
      load(HVEC + 1, NOP);
      run();
      wait_pc(1, "R8 ion completes to fetch");
      check("R8 ie set", 32'(ie), 1);
      wait_for(2'b11, 2'd1, "R8 interrupt entered");
      check("R9 save strobe", 32'(bus_wr), 1);
      check("R9 save addr", 32'(bus_addr), SAVE);
      check("R9 saved pc", 32'(bus_wdata), 2);
      wait_for(2'b00, 2'd0, "R9 back to fetch");
      check("R9 pc vector", 32'(pc), HVEC);
      check("R9 ie cleared", 32'(ie), 0);
      wait_pc(HVEC + 1, "R9 no re-entry while disabled");
      irq = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule